// File: doc/BRIEF.md
# Optical black clamp loop

This block holds the black level of a digitized CCD pixel stream at a programmable target. Each valid 10-bit sample has a signed correction added to it, and the result leaves the block through one output register, saturated to the sample range. While a clamp strobe marks the shielded (optical black) pixels of a line, the block compares each corrected sample with the black target. It then moves the correction by one sixteenth of the difference. The correction therefore servos toward the target over a window of a few tens of pixels, and pixel noise is filtered out.

The target is an 8-bit code in quarter-LSB units, held in a local register that resets to code 128, which is 32 LSB. A disable input stops the servo. In that state the same target code is added to every sample as a fixed offset, and the servo's correction stays frozen until the loop is enabled again. The strobe can be active high or active low, as selected by a polarity input.

Top module: `obc_clamp_loop`

## Requirements
- R1: After a synchronous reset, `out_vld` and `out_data` are 0, the servo correction is 0 and the target code is 128 (32 LSB).
- R2: A cycle with `lvl_we` high loads `lvl_wdata` into the target code at that clock edge. Code k means k/4 LSB, and samples from the next cycle on use the new code.
- R3: While `loop_off` is 1, a valid sample s gives `out_data` = min(1023, floor(s + code/4)). The servo correction is left unchanged, even inside the clamp window.
- R4: While `loop_off` is 0, a valid sample s with correction c (a signed count of quarter LSBs) gives `out_data` = floor((4s + c)/4), saturated.
- R5: With `strobe_hi` = 1 the clamp window is open while `ob_strobe` is 1. With `strobe_hi` = 0 the window is open while `ob_strobe` is 0.
- R6: For a valid sample inside the window with the loop on, the correction becomes c + ((code - (4s + c)) >>> 4), using an arithmetic (floor) shift, clipped to the signed 14-bit range. The new value applies from the next sample.
- R7: The correction does not change on cycles outside the window or with `sample_vld` low.
- R8: `out_data` saturates at 0 for a negative corrected value and at 1023 for a corrected value of 1023 LSB or more.
- R9: `out_data` and `out_vld` update at the clock edge that takes a sample. A cycle with `sample_vld` low gives `out_vld` = 0 and leaves `out_data` unchanged.
- R10: A constant sample held inside the window for 200 samples brings the output to no more than 4 LSB below the target and not above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| lvl_we | input | 1 | Load strobe for the target code |
| lvl_wdata | input | 8 | New target code, quarter-LSB units |
| loop_off | input | 1 | 1 = servo frozen, static offset from the target code |
| strobe_hi | input | 1 | Clamp strobe polarity, 1 = active high |
| ob_strobe | input | 1 | Clamp window strobe (optical black pixels) |
| sample_vld | input | 1 | Sample qualifier |
| sample | input | 10 | Digitized pixel sample |
| out_vld | output | 1 | Corrected sample valid |
| out_data | output | 10 | Corrected, saturated pixel |

## Verification
The bench builds the block with its defaults: 10-bit samples, an 8-bit target, 2 fractional bits, a 14-bit correction and a 4-bit filter shift. At that size every sample code can be swept under six target codes in static mode, including the upper saturation corner. The 1/16 servo step lets the bench drive the correction to both output rails and to a settled black level within a few hundred window samples. Through all of this it predicts every output value with its own arithmetic model of the correction.

// File: rtl/obc_pkg.sv
package obc_pkg;

    localparam int OBC_DW      = 10;   // sample width
    localparam int OBC_LW      = 8;    // target code width
    localparam int OBC_FRAC    = 2;    // fractional bits of target and correction
    localparam int OBC_OFFW    = 14;   // signed correction width
    localparam int OBC_SHIFT   = 4;    // filter gain = 2^-SHIFT
    localparam int OBC_LVL_RST = 128;  // target code after reset

    typedef enum logic {
        MODE_STATIC = 1'b0,
        MODE_SERVO  = 1'b1
    } obc_mode_e;

    typedef struct packed {
        logic      vld;
        logic      win;
        obc_mode_e mode;
    } obc_ctl_t;

    function automatic int obc_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // internal arithmetic width: room for the shifted sample, the correction and a guard
    function automatic int obc_calc_w(input int dw, input int frac, input int offw);
        return obc_max(dw + frac + 1, offw) + 2;
    endfunction

endpackage

// File: rtl/obc_level_reg.sv
module obc_level_reg #(
    parameter int LW  = obc_pkg::OBC_LW,
    parameter int RST = obc_pkg::OBC_LVL_RST
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [LW-1:0] wdata,
    output logic [LW-1:0] lvl
);

    localparam logic [LW-1:0] RST_CODE = LW'(RST);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl <= RST_CODE;
        end else if (we) begin
            lvl <= wdata;
        end
    end

    AST_LVL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(lvl)); // R2

endmodule

// File: rtl/obc_window.sv
module obc_window
    import obc_pkg::*;
(
    input  logic     strobe_hi,
    input  logic     strobe,
    input  logic     loop_off,
    input  logic     vld,
    output obc_ctl_t ctl
);

    always_comb begin
        ctl.vld  = vld;
        ctl.win  = strobe_hi ? strobe : ~strobe;
        ctl.mode = loop_off ? MODE_STATIC : MODE_SERVO;
    end

endmodule

// File: rtl/obc_servo.sv
module obc_servo
    import obc_pkg::*;
#(
    parameter int LW    = OBC_LW,
    parameter int OFFW  = OBC_OFFW,
    parameter int SHIFT = OBC_SHIFT,
    parameter int CW    = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  obc_ctl_t               ctl,
    input  logic [LW-1:0]          lvl,
    input  logic signed [CW-1:0]   corr_q,
    output logic signed [OFFW-1:0] off_q
);

    localparam int CW1 = CW + 1;
    localparam logic signed [CW:0] OMAX = CW1'((1 <<< (OFFW - 1)) - 1);
    localparam logic signed [CW:0] OMIN = -OMAX - CW1'(1);

    logic signed [CW-1:0] tgt_q;
    logic signed [CW-1:0] err_q;
    logic signed [CW-1:0] step_q;
    logic signed [CW:0]   sum_q;
    logic                 upd;

    always_comb begin
        tgt_q  = {{(CW - LW){1'b0}}, lvl};
        err_q  = tgt_q - corr_q;
        step_q = err_q >>> SHIFT;
        sum_q  = {{(CW1 - OFFW){off_q[OFFW-1]}}, off_q} + {step_q[CW-1], step_q};
        upd    = ctl.vld && ctl.win && (ctl.mode == MODE_SERVO);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q <= '0;
        end else if (upd) begin
            if (sum_q > OMAX) begin
                off_q <= OMAX[OFFW-1:0];
            end else if (sum_q < OMIN) begin
                off_q <= OMIN[OFFW-1:0];
            end else begin
                off_q <= sum_q[OFFW-1:0];
            end
        end
    end

    AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !(ctl.vld && ctl.win) |=> $stable(off_q)); // R7

    AST_OFF_STATIC: assert property (@(posedge clk) disable iff (rst)
        (ctl.mode == MODE_STATIC) |=> $stable(off_q)); // R3

endmodule

// File: rtl/obc_correct.sv
module obc_correct
    import obc_pkg::*;
#(
    parameter int DW   = OBC_DW,
    parameter int LW   = OBC_LW,
    parameter int FRAC = OBC_FRAC,
    parameter int OFFW = OBC_OFFW,
    parameter int CW   = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  obc_ctl_t               ctl,
    input  logic [DW-1:0]          sample,
    input  logic [LW-1:0]          lvl,
    input  logic signed [OFFW-1:0] off_q,
    output logic signed [CW-1:0]   corr_q,
    output logic                   out_vld,
    output logic [DW-1:0]          out_data
);

    localparam logic signed [CW-1:0] MAXV = CW'((1 << DW) - 1);
    localparam logic signed [CW-1:0] MAXQ = CW'(((1 << DW) - 1) * (1 << FRAC));

    logic signed [CW-1:0] samp_q;
    logic signed [CW-1:0] add_q;
    logic signed [CW-1:0] whole_q;
    logic [DW-1:0]        sat_d;

    always_comb begin
        samp_q = {{(CW - DW - FRAC){1'b0}}, sample, {FRAC{1'b0}}};
        if (ctl.mode == MODE_SERVO) begin
            add_q = {{(CW - OFFW){off_q[OFFW-1]}}, off_q};
        end else begin
            add_q = {{(CW - LW){1'b0}}, lvl};
        end
        corr_q  = samp_q + add_q;
        whole_q = corr_q >>> FRAC;
        if (whole_q < 0) begin
            sat_d = '0;
        end else if (whole_q > MAXV) begin
            sat_d = '1;
        end else begin
            sat_d = whole_q[DW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_data <= '0;
        end else begin
            out_vld <= ctl.vld;
            if (ctl.vld) begin
                out_data <= sat_d;
            end
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctl.vld |=> ($stable(out_data) && !out_vld)); // R9

    AST_SAT_TOP: assert property (@(posedge clk) disable iff (rst)
        (ctl.vld && corr_q >= MAXQ) |=> (out_data == '1)); // R8

    AST_SAT_BOT: assert property (@(posedge clk) disable iff (rst)
        (ctl.vld && corr_q < 0) |=> (out_data == '0)); // R8

endmodule

// File: rtl/obc_clamp_loop.sv
module obc_clamp_loop
    import obc_pkg::*;
#(
    parameter int DW    = OBC_DW,
    parameter int LW    = OBC_LW,
    parameter int FRAC  = OBC_FRAC,
    parameter int OFFW  = OBC_OFFW,
    parameter int SHIFT = OBC_SHIFT,
    parameter int LRST  = OBC_LVL_RST
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lvl_we,
    input  logic [LW-1:0] lvl_wdata,
    input  logic          loop_off,
    input  logic          strobe_hi,
    input  logic          ob_strobe,
    input  logic          sample_vld,
    input  logic [DW-1:0] sample,
    output logic          out_vld,
    output logic [DW-1:0] out_data
);

    localparam int CW = obc_calc_w(DW, FRAC, OFFW);

    obc_ctl_t               ctl;
    logic [LW-1:0]          lvl;
    logic signed [OFFW-1:0] off_q;
    logic signed [CW-1:0]   corr_q;

    obc_level_reg #(.LW(LW), .RST(LRST)) u_lvl (
        .clk   (clk),
        .rst   (rst),
        .we    (lvl_we),
        .wdata (lvl_wdata),
        .lvl   (lvl)
    );

    obc_window u_win (
        .strobe_hi (strobe_hi),
        .strobe    (ob_strobe),
        .loop_off  (loop_off),
        .vld       (sample_vld),
        .ctl       (ctl)
    );

    obc_servo #(.LW(LW), .OFFW(OFFW), .SHIFT(SHIFT), .CW(CW)) u_servo (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .lvl    (lvl),
        .corr_q (corr_q),
        .off_q  (off_q)
    );

    obc_correct #(.DW(DW), .LW(LW), .FRAC(FRAC), .OFFW(OFFW), .CW(CW)) u_corr (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .sample   (sample),
        .lvl      (lvl),
        .off_q    (off_q),
        .corr_q   (corr_q),
        .out_vld  (out_vld),
        .out_data (out_data)
    );

endmodule

// File: tb/sim_obc_clamp_loop.sv
module sim_obc_clamp_loop;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lvl_we = 1'b0;
    logic [7:0] lvl_wdata = '0;
    logic       loop_off = 1'b0;
    logic       strobe_hi = 1'b1;
    logic       ob_strobe = 1'b0;
    logic       sample_vld = 1'b0;
    logic [9:0] sample = '0;
    logic       out_vld;
    logic [9:0] out_data;

    int n_run = 0;
    int n_fail = 0;
    int m_lvl = 128;
    int m_off = 0;
    int m_last = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    obc_clamp_loop u0 (
        .clk        (clk),
        .rst        (rst),
        .lvl_we     (lvl_we),
        .lvl_wdata  (lvl_wdata),
        .loop_off   (loop_off),
        .strobe_hi  (strobe_hi),
        .ob_strobe  (ob_strobe),
        .sample_vld (sample_vld),
        .sample     (sample),
        .out_vld    (out_vld),
        .out_data   (out_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clip(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    // drive one cycle from a negedge, check after the next posedge
    task automatic drive(input int s, input bit strb, input bit vld, input bit off, input string req);
        int corr;
        int ex;
        bit win;
        sample     = 10'(s);
        ob_strobe  = strb;
        sample_vld = vld;
        loop_off   = off;
        win  = strobe_hi ? strb : !strb;
        corr = s * 4 + (off ? m_lvl : m_off);
        ex   = vld ? clip(corr >>> 2, 0, 1023) : m_last;
        @(negedge clk);
        chk(out_vld == vld, req, int'(out_vld), int'(vld));
        chk(int'(out_data) == ex, req, int'(out_data), ex);
        m_last = ex;
        if (vld && !off && win) begin
            m_off = clip(m_off + ((m_lvl - corr) >>> 4), -8192, 8191);
        end
    endtask

    task automatic write_lvl(input int v);
        lvl_we     = 1'b1;
        lvl_wdata  = 8'(v);
        sample_vld = 1'b0;
        @(negedge clk);
        lvl_we = 1'b0;
        m_lvl  = v;
        chk(out_vld == 1'b0, "R9", int'(out_vld), 0);
        chk(int'(out_data) == m_last, "R9", int'(out_data), m_last);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int lvls[6] = '{0, 1, 2, 3, 128, 255};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(out_vld == 1'b0, "R1", int'(out_vld), 0);
        chk(out_data == 10'd0, "R1", int'(out_data), 0);
        drive(0, 1'b0, 1'b1, 1'b1, "R1");
        chk(out_data == 10'd32, "R1", int'(out_data), 32);

        // R3 / R8: static offset sweep, window held open to show the servo is frozen
        strobe_hi = 1'b1;
        foreach (lvls[i]) begin
            write_lvl(lvls[i]);
            for (int s = 0; s < 1024; s++) drive(s, 1'b1, 1'b1, 1'b1, "R3");
        end
        drive(1023, 1'b1, 1'b1, 1'b1, "R8");

        // R4 / R7: loop on, window closed, zero correction passes samples through
        write_lvl(128);
        for (int s = 0; s < 1024; s++) drive(s, 1'b0, 1'b1, 1'b0, "R7");

        // R9: invalid cycle inside the window changes neither output nor correction
        drive(5, 1'b1, 1'b0, 1'b0, "R9");
        drive(40, 1'b0, 1'b1, 1'b0, "R7");
        chk(out_data == 10'd40, "R7", int'(out_data), 40);

        // R6: one window step, error 128 -> correction 8 quarters
        drive(0, 1'b1, 1'b1, 1'b0, "R6");
        drive(10, 1'b0, 1'b1, 1'b0, "R6");
        chk(out_data == 10'd12, "R6", int'(out_data), 12);

        // R5: active-low strobe
        strobe_hi = 1'b0;
        drive(10, 1'b1, 1'b1, 1'b0, "R5");
        chk(out_data == 10'd12, "R5", int'(out_data), 12);
        drive(0, 1'b0, 1'b1, 1'b0, "R5");
        drive(10, 1'b1, 1'b1, 1'b0, "R5");
        chk(out_data == 10'd13, "R5", int'(out_data), 13);

        // R3: loop off inside an open window, then the correction is unchanged
        drive(0, 1'b0, 1'b1, 1'b1, "R3");
        chk(out_data == 10'd32, "R3", int'(out_data), 32);
        drive(10, 1'b1, 1'b1, 1'b0, "R3");
        chk(out_data == 10'd13, "R3", int'(out_data), 13);

        // R10: settling on a constant black input
        strobe_hi = 1'b1;
        repeat (200) drive(100, 1'b1, 1'b1, 1'b0, "R10");
        drive(100, 1'b0, 1'b1, 1'b0, "R10");
        chk(out_data >= 10'd28 && out_data <= 10'd32, "R10", int'(out_data), 32);

        // R8: drive the correction to both rails
        write_lvl(255);
        repeat (300) drive(0, 1'b1, 1'b1, 1'b0, "R8");
        drive(1023, 1'b0, 1'b1, 1'b0, "R8");
        chk(out_data == 10'd1023, "R8", int'(out_data), 1023);
        write_lvl(0);
        repeat (600) drive(1023, 1'b1, 1'b1, 1'b0, "R8");
        drive(0, 1'b0, 1'b1, 1'b0, "R8");
        chk(out_data == 10'd0, "R8", int'(out_data), 0);
        drive(500, 1'b0, 1'b1, 1'b0, "R4");

        // R2: fractional target code
        write_lvl(7);
        drive(0, 1'b0, 1'b1, 1'b1, "R2");
        chk(out_data == 10'd1, "R2", int'(out_data), 1);
        drive(1, 1'b0, 1'b1, 1'b1, "R2");
        chk(out_data == 10'd2, "R2", int'(out_data), 2);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule